// File: doc/BRIEF.md
# Four-Word Accumulator Machine

This block is a minimal accumulator processor. A 2-bit program counter picks one of four 8-bit instruction words presented on input ports. A fetch step copies the chosen word into an instruction register and advances the counter. The instruction register is then split into a one-bit function select (bit 7) and a 7-bit unsigned operand (bits 6..0). An execute step combines the zero-extended operand with an 8-bit accumulator, by AND or by ADD, and writes the result back into the accumulator.

A built-in three-phase sequencer (fetch, decode, execute) produces the load and increment strobes. A mode pin hands those strobes to external pins instead, so the datapath can be stepped by hand. The instruction words, the strobes and the mode are plain level inputs with no handshake. The program counter, instruction register, accumulator and current phase are brought out as outputs.

Top module: `accum_machine`

## Requirements
- R1: A synchronous reset clears the program counter, instruction register and accumulator to 0 and puts the sequencer in the fetch phase (phase code 0; decode is 1, execute is 2).
- R2: In automatic mode (`manual_mode`=0) the phase advances fetch, decode, execute, fetch, one phase per clock.
- R3: When the instruction-load strobe is active at a rising edge, the instruction register takes the whole word selected by the program counter (0 selects `instr0`, 1 `instr1`, 2 `instr2`, 3 `instr3`).
- R4: When the increment strobe is active at a rising edge, the program counter increases by one and wraps from 3 to 0.
- R5: Instruction bit 7 equal to 0 makes execute write `acc & {1'b0, ir[6:0]}` to the accumulator.
- R6: Instruction bit 7 equal to 1 makes execute write `(acc + {1'b0, ir[6:0]}) mod 256` to the accumulator.
- R7: In automatic mode, fetch raises both the load and increment strobes, decode raises none, and execute raises the accumulator-load strobe with the function select equal to instruction bit 7. The external strobe pins have no effect in this mode.
- R8: In manual mode (`manual_mode`=1), `man_ld_ir`, `man_pc_inc`, `man_ld_acc` and `man_alu_add` drive the datapath directly, and the sequencer phase holds its value.
- R9: Registers whose strobe is inactive at an edge keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| manual_mode | input | 1 | 0 = sequencer drives the strobes, 1 = the pins drive them |
| man_ld_ir | input | 1 | Manual instruction-load strobe |
| man_pc_inc | input | 1 | Manual counter-increment strobe |
| man_ld_acc | input | 1 | Manual accumulator-load strobe |
| man_alu_add | input | 1 | Manual function select, 1 = ADD |
| instr0 | input | 8 | Instruction word at address 0 |
| instr1 | input | 8 | Instruction word at address 1 |
| instr2 | input | 8 | Instruction word at address 2 |
| instr3 | input | 8 | Instruction word at address 3 |
| pc | output | 2 | Program counter |
| ir | output | 8 | Instruction register |
| acc | output | 8 | Accumulator |
| phase | output | 2 | Sequencer phase code |

## Verification
A wrong phase shows on `phase` at once, and within one cycle as a misplaced counter step or instruction load. A wrong opcode split or ALU function is invisible until the next execute edge, and then it shows on `acc`. From that point every later accumulator value differs from the model. A counter that fails to wrap shows as the wrong word in `ir` on the fifth fetch. The bench's reference model tracks all four registers and compares them after every edge, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NWORDS = 1 << ADDR_W;
  localparam int unsigned OPC_BIT = WORD_W - 1;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2
  } phase_e;

  typedef struct packed {
    logic ld_ir;
    logic pc_inc;
    logic ld_acc;
    logic alu_add;
  } strobes_t;
endpackage

// File: rtl/accum_seq.sv
module accum_seq
  import accum_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  logic     opcode,
  output phase_e   phase,
  output strobes_t strb
);
  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_FETCH;
    else if (!hold) begin
      unique case (phase_q)
        PH_FETCH:  phase_q <= PH_DECODE;
        PH_DECODE: phase_q <= PH_EXEC;
        default:   phase_q <= PH_FETCH;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    unique case (phase_q)
      PH_FETCH: begin
        strb.ld_ir  = 1'b1;
        strb.pc_inc = 1'b1;
      end
      PH_EXEC: begin
        strb.ld_acc  = 1'b1;
        strb.alu_add = opcode;
      end
      default: strb = '0;
    endcase
  end

  assign phase = phase_q;
endmodule

// File: rtl/accum_alu.sv
module accum_alu #(
  parameter int unsigned W = 8
) (
  input  logic         add_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    if (add_sel) y = a + b;
    else         y = a & b;
  end
endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  strobes_t                     strb,
  input  logic [NWORDS-1:0][WORD_W-1:0] words,
  output logic [ADDR_W-1:0]            pc,
  output logic [WORD_W-1:0]            ir,
  output logic [WORD_W-1:0]            acc
);
  localparam int unsigned OPND_W = WORD_W - 1;

  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q, acc_q, operand, alu_y;

  assign operand = {1'b0, ir_q[OPND_W-1:0]};

  accum_alu #(.W(WORD_W)) u_alu (
    .add_sel (strb.alu_add),
    .a       (acc_q),
    .b       (operand),
    .y       (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (strb.ld_ir)  ir_q  <= words[pc_q];
      if (strb.pc_inc) pc_q  <= pc_q + 1'b1;
      if (strb.ld_acc) acc_q <= alu_y;
    end
  end

  assign pc  = pc_q;
  assign ir  = ir_q;
  assign acc = acc_q;
endmodule

// File: rtl/accum_machine.sv
module accum_machine
  import accum_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       manual_mode,
  input  logic       man_ld_ir,
  input  logic       man_pc_inc,
  input  logic       man_ld_acc,
  input  logic       man_alu_add,
  input  logic [7:0] instr0,
  input  logic [7:0] instr1,
  input  logic [7:0] instr2,
  input  logic [7:0] instr3,
  output logic [1:0] pc,
  output logic [7:0] ir,
  output logic [7:0] acc,
  output logic [1:0] phase
);
  phase_e   seq_phase;
  strobes_t seq_strb, man_strb, strb;
  logic [NWORDS-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0] ir_w;

  assign words = {instr3, instr2, instr1, instr0};
  assign man_strb = '{ld_ir: man_ld_ir, pc_inc: man_pc_inc,
                      ld_acc: man_ld_acc, alu_add: man_alu_add};
  assign strb = manual_mode ? man_strb : seq_strb;

  accum_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .hold   (manual_mode),
    .opcode (ir_w[OPC_BIT]),
    .phase  (seq_phase),
    .strb   (seq_strb)
  );

  accum_datapath u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .words (words),
    .pc    (pc),
    .ir    (ir_w),
    .acc   (acc)
  );

  assign ir    = ir_w;
  assign phase = seq_phase;
endmodule

// File: rtl/accum_machine_chk.sv
module accum_machine_chk (
  input logic       clk,
  input logic       rst,
  input logic       manual_mode,
  input logic       man_pc_inc,
  input logic       man_ld_ir,
  input logic       man_ld_acc,
  input logic [1:0] pc,
  input logic [7:0] ir,
  input logic [7:0] acc,
  input logic [1:0] phase
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pc == 2'd0 && ir == 8'd0 && acc == 8'd0 && phase == 2'd0)); // R1
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst) phase != 2'd3); // R2
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst) (!manual_mode && phase == 2'd0) |=> phase == 2'd1); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) (!manual_mode && phase == 2'd0) |=> pc == $past(pc) + 2'd1); // R4
  AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (rst) (!manual_mode && phase == 2'd1) |=> ($stable(pc) && $stable(ir) && $stable(acc))); // R7
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst) manual_mode |=> $stable(phase)); // R8
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst) (manual_mode && !man_pc_inc && !man_ld_ir && !man_ld_acc) |=> ($stable(pc) && $stable(ir) && $stable(acc))); // R9
endmodule

bind accum_machine accum_machine_chk u_chk (
  .clk(clk), .rst(rst), .manual_mode(manual_mode), .man_pc_inc(man_pc_inc),
  .man_ld_ir(man_ld_ir), .man_ld_acc(man_ld_acc),
  .pc(pc), .ir(ir), .acc(acc), .phase(phase)
);

// File: tb/tb_accum_machine.sv
module tb_accum_machine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic manual_mode = 1'b0;
  logic man_ld_ir = 1'b0, man_pc_inc = 1'b0, man_ld_acc = 1'b0, man_alu_add = 1'b0;
  logic [7:0] instr0 = 8'h00, instr1 = 8'h00, instr2 = 8'h00, instr3 = 8'h00;
  logic [1:0] pc, phase;
  logic [7:0] ir, acc;

  int checks = 0;
  int failures = 0;
  int m_pc, m_ir, m_acc, m_ph;
  bit done = 0;

  always #4 clk = ~clk;

  accum_machine dut (.*);

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int word_at(input int a);
    case (a)
      0: return instr0;
      1: return instr1;
      2: return instr2;
      default: return instr3;
    endcase
  endfunction

  // Reference step: applies the effect of one rising edge to the model.
  task automatic model_edge();
    int li, pi, la, ad, nir, npc, nacc;
    if (rst) begin
      m_pc = 0; m_ir = 0; m_acc = 0; m_ph = 0;
      return;
    end
    if (manual_mode) begin
      li = man_ld_ir; pi = man_pc_inc; la = man_ld_acc; ad = man_alu_add;
    end else begin
      li = (m_ph == 0); pi = (m_ph == 0); la = (m_ph == 2); ad = (m_ir >> 7) & 1;
      m_ph = (m_ph + 1) % 3;
    end
    nir = li ? word_at(m_pc) : m_ir;
    npc = pi ? (m_pc + 1) % 4 : m_pc;
    if (la) nacc = ad ? (m_acc + (m_ir & 127)) % 256 : (m_acc & (m_ir & 127));
    else nacc = m_acc;
    m_ir = nir; m_pc = npc; m_acc = nacc;
  endtask

  task automatic compare(input string req);
    chk(req, pc, m_pc, "pc");
    chk(req, ir, m_ir, "ir");
    chk(req, acc, m_acc, "acc");
    chk(req, phase, m_ph, "phase");
  endtask

  // Inputs are changed at the falling edge; model updated at rising edge; compare just before the next change.
  task automatic cycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      #2;
      compare(req);
      @(negedge clk);
    end
  endtask

  initial begin
    m_pc = 0; m_ir = 0; m_acc = 0; m_ph = 0;
    @(negedge clk);
    cycles(2, "R1");
    rst = 1'b0;
    // R5/R6: program mixing ADD and AND; external pins toggled to show R7 ignores them
    instr0 = 8'h93;  // ADD 19
    instr1 = 8'hFF;  // ADD 127
    instr2 = 8'h3C;  // AND 60
    instr3 = 8'h85;  // ADD 5
    man_ld_acc = 1'b1; man_alu_add = 1'b1;
    cycles(12, "R2 R3 R4 R5 R6 R7");
    // Second lap: counter has wrapped (R4); ADD overflow wraps (R6)
    instr0 = 8'hFF; instr1 = 8'hFF; instr2 = 8'hFF; instr3 = 8'h7F;
    cycles(12, "R4 R6 R5");
    // Manual mode, phase holds (R8); idle cycles keep state (R9)
    manual_mode = 1'b1; man_ld_acc = 1'b0; man_alu_add = 1'b0;
    cycles(3, "R8 R9");
    man_ld_ir = 1'b1;
    cycles(1, "R8 R3");
    man_ld_ir = 1'b0; man_pc_inc = 1'b1;
    cycles(3, "R8 R4");
    man_pc_inc = 1'b0; man_ld_acc = 1'b1; man_alu_add = 1'b0;
    cycles(1, "R8 R5");
    man_alu_add = 1'b1;
    cycles(2, "R8 R6");
    man_ld_acc = 1'b0; man_alu_add = 1'b0;
    cycles(2, "R9");
    // Back to automatic from the held phase
    manual_mode = 1'b0;
    instr0 = 8'h0F; instr1 = 8'h81; instr2 = 8'h70; instr3 = 8'hC0;
    cycles(9, "R2 R7");
    // Reset mid-run
    rst = 1'b1;
    cycles(1, "R1");
    rst = 1'b0;
    cycles(6, "R2 R3");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule